// File: doc/BRIEF.md
# Non-Maskable Interrupt Source Latch and Control

The block collects two hardware error causes for a legacy PC style system and turns them into a single active-low non-maskable interrupt. One cause is a system board parity or system error (active-high event input), the other an active-low channel-check input. Each cause has a disable bit. When the bit is 0 the cause can latch its status. When the bit is 1 the status is held clear, so software clears a serviced cause by writing the bit to 1 and then back to 0.

All access goes through one 8-bit control/status register at I/O port 61h. The same register reads back the speaker timer output and a refresh toggle, and it holds the speaker data and timer gate bits, which drive outputs. A second port at 70h carries a global interrupt mask in its top bit. The lower seven bits written there belong to the real-time clock index and are passed through to it unchanged, with a one-cycle write strobe. The bus is a plain address, data, read-strobe and write-strobe interface. Reset is synchronous and active high, and every output comes from a register.

Top module: `nmi_src_ctl`

## Requirements
- R1: A read of port 61h returns, in the following cycle on `io_rdata`, bit 7 = parity status, bit 6 = channel-check status, bit 5 = `spk_tmr_out`, bit 4 = refresh toggle, bit 3 = channel-check disable, bit 2 = parity disable, bit 1 = speaker data, bit 0 = timer gate. All values are taken from before that clock edge. In any cycle without a read of 61h, `io_rdata` is 0.
- R2: The parity status sets on the rising edge of (`perr_evt` high and bit 2 = 0). It stays set after `perr_evt` falls.
- R3: The channel-check status sets on the rising edge of (`iochk_n` low and bit 3 = 0). It stays set after `iochk_n` returns high.
- R4: While a disable bit is 1, its status is 0. Writing the bit to 1 and then to 0 clears a latched status. A write that sets the disable bit in the same cycle as a cause edge leaves the status at 0.
- R5: The refresh toggle inverts once at the end of every cycle in which `refresh_pulse` is high.
- R6: `nmi_n` is low in the cycle after a cycle in which either status is 1 and the mask is 0. Otherwise it is high.
- R7: A write to 61h stores bit 1 into `spk_data` and bit 0 into `tmr_gate` (1 = counter enabled), visible the next cycle.
- R8: A write to 70h stores bit 7 as the global mask (1 = NMI blocked, for example 80h). It also presents bits 6:0 on `rtc_idx`, with `rtc_idx_wr` high for exactly the next cycle.
- R9: Bits 7:4 of a write to 61h have no effect on the statuses or on what is read back.
- R10: After reset, bits 3:2 = 11, both statuses are 0, the mask is 1, bits 1:0 = 0, the refresh toggle is 0, `nmi_n` = 1 and `io_rdata` = 0.
- R11: Writing a disable bit to 0 while its error is still active sets the status, because the enabled error counts as a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Registered read data |
| perr_evt | input | 1 | Parity/system error, active high |
| iochk_n | input | 1 | Channel check, active low |
| spk_tmr_out | input | 1 | Speaker timer output |
| refresh_pulse | input | 1 | One-cycle refresh indication |
| spk_data | output | 1 | Speaker data bit |
| tmr_gate | output | 1 | Speaker timer gate |
| rtc_idx | output | 7 | Index passed to the RTC |
| rtc_idx_wr | output | 1 | RTC index write strobe |
| nmi_n | output | 1 | Non-maskable interrupt, active low |

## Verification
A cause edge can arrive in the same cycle as a software write that sets or clears that cause's disable bit, and a refresh pulse or a status change can coincide with a read of port 61h. The bench provokes these directly: it raises `perr_evt` together with a write of bit 2, holds `iochk_n` low across a re-enable, and reads while pulsing refresh. It also issues long random mixes of all inputs. A behavioural model compares every output on every clock, and it judges the clear-wins and old-value-on-read rules stated in R4 and R1.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  localparam int NSRC      = 2;
  localparam int SRC_PERR  = 0;
  localparam int SRC_IOCHK = 1;
  localparam int B_GATE    = 0;
  localparam int B_SPK     = 1;
  localparam int B_DIS0    = 2;
  localparam int B_MASK    = 7;
  localparam int IDX_W     = 7;
endpackage

// File: rtl/nmi_cause_latch.sv
module nmi_cause_latch (
  input  logic clk,
  input  logic rst,
  input  logic err_act,
  input  logic dis_q,
  input  logic dis_d,
  output logic stat_q
);
  logic qual, qual_q;
  assign qual = err_act & ~dis_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      qual_q <= qual;
      stat_q <= (stat_q | (qual & ~qual_q)) & ~dis_d;
    end
  end
endmodule

// File: rtl/nmi_regfile.sv
module nmi_regfile
  import nmi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_PORT = 'h61,
  parameter logic [ADDR_W-1:0] CMOS_PORT = 'h70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [NSRC-1:0]   stat_q,
  input  logic              spk_tmr_out,
  input  logic              refresh_pulse,
  output logic [NSRC-1:0]   dis_q,
  output logic [NSRC-1:0]   dis_d,
  output logic              mask_q,
  output logic              spk_q,
  output logic              gate_q,
  output logic [IDX_W-1:0]  rtc_idx,
  output logic              rtc_idx_wr,
  output logic [7:0]        io_rdata
);
  logic ctrl_wr, cmos_wr, ctrl_rd, tog_q;
  assign ctrl_wr = io_wr && (io_addr == CTRL_PORT);
  assign cmos_wr = io_wr && (io_addr == CMOS_PORT);
  assign ctrl_rd = io_rd && (io_addr == CTRL_PORT);

  assign dis_d = ctrl_wr ? io_wdata[B_DIS0 +: NSRC] : dis_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q      <= '1;
      mask_q     <= 1'b1;
      spk_q      <= 1'b0;
      gate_q     <= 1'b0;
      tog_q      <= 1'b0;
      rtc_idx    <= '0;
      rtc_idx_wr <= 1'b0;
      io_rdata   <= '0;
    end else begin
      dis_q      <= dis_d;
      tog_q      <= tog_q ^ refresh_pulse;
      rtc_idx_wr <= cmos_wr;
      if (ctrl_wr) begin
        spk_q  <= io_wdata[B_SPK];
        gate_q <= io_wdata[B_GATE];
      end
      if (cmos_wr) begin
        mask_q  <= io_wdata[B_MASK];
        rtc_idx <= io_wdata[IDX_W-1:0];
      end
      if (ctrl_rd)
        io_rdata <= {stat_q[SRC_PERR], stat_q[SRC_IOCHK], spk_tmr_out, tog_q,
                     dis_q[SRC_IOCHK], dis_q[SRC_PERR], spk_q, gate_q};
      else
        io_rdata <= '0;
    end
  end
endmodule

// File: rtl/nmi_src_ctl.sv
module nmi_src_ctl
  import nmi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_PORT = 'h61,
  parameter logic [ADDR_W-1:0] CMOS_PORT = 'h70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  input  logic              perr_evt,
  input  logic              iochk_n,
  input  logic              spk_tmr_out,
  input  logic              refresh_pulse,
  output logic              spk_data,
  output logic              tmr_gate,
  output logic [6:0]        rtc_idx,
  output logic              rtc_idx_wr,
  output logic              nmi_n
);
  logic [NSRC-1:0] stat_q, dis_q, dis_d, err_act;
  logic            mask_q;

  assign err_act[SRC_PERR]  = perr_evt;
  assign err_act[SRC_IOCHK] = ~iochk_n;

  nmi_regfile #(.ADDR_W(ADDR_W), .CTRL_PORT(CTRL_PORT), .CMOS_PORT(CMOS_PORT)) regs_i (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
    .io_rd(io_rd), .stat_q(stat_q), .spk_tmr_out(spk_tmr_out),
    .refresh_pulse(refresh_pulse), .dis_q(dis_q), .dis_d(dis_d), .mask_q(mask_q),
    .spk_q(spk_data), .gate_q(tmr_gate), .rtc_idx(rtc_idx), .rtc_idx_wr(rtc_idx_wr),
    .io_rdata(io_rdata)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    nmi_cause_latch latch_i (
      .clk(clk), .rst(rst), .err_act(err_act[g]),
      .dis_q(dis_q[g]), .dis_d(dis_d[g]), .stat_q(stat_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) nmi_n <= 1'b1;
    else     nmi_n <= ~((|stat_q) & ~mask_q);
  end
endmodule

// File: rtl/nmi_src_ctl_chk.sv
module nmi_src_ctl_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CMOS_PORT = 'h70
) (
  input logic              clk,
  input logic              rst,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic              nmi_n,
  input logic              rtc_idx_wr,
  input logic              mask_q,
  input logic [1:0]        stat_q,
  input logic [1:0]        dis_q
);
  // R10
  reset_quiet_chk: assert property (@(posedge clk) rst |=> nmi_n);
  // R6
  mask_blocks_chk: assert property (@(posedge clk) disable iff (rst) mask_q |=> nmi_n);
  // R6
  nmi_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !nmi_n |-> $past(|stat_q));
  // R4
  dis_holds_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (dis_q[0] |-> !stat_q[0]) and (dis_q[1] |-> !stat_q[1]));
  // R4
  clear_only_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(stat_q[0]) |-> dis_q[0]) and ($fell(stat_q[1]) |-> dis_q[1]));
  // R8
  rtc_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rtc_idx_wr |-> $past(io_wr && io_addr == CMOS_PORT));
endmodule

bind nmi_src_ctl nmi_src_ctl_chk #(.ADDR_W(ADDR_W), .CMOS_PORT(CMOS_PORT)) chk_i (
  .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .nmi_n(nmi_n),
  .rtc_idx_wr(rtc_idx_wr), .mask_q(mask_q), .stat_q(stat_q), .dis_q(dis_q)
);

// File: tb/nmi_src_ctl_tb.sv
`timescale 1ns/1ps
module nmi_src_ctl_tb_top;
  logic clk = 0, rst = 1;
  logic [15:0] io_addr = 0;
  logic [7:0]  io_wdata = 0, io_rdata;
  logic io_wr = 0, io_rd = 0, perr_evt = 0, iochk_n = 1, spk_tmr_out = 0, refresh_pulse = 0;
  logic spk_data, tmr_gate, rtc_idx_wr, nmi_n;
  logic [6:0] rtc_idx;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nmi_src_ctl dut_i (.*);

  // behavioural reference state
  bit m_stp, m_sti, m_dp, m_di, m_spk, m_gate, m_mask, m_tog, m_qp, m_qi, m_nmi, m_rw;
  bit [7:0] m_rd;
  bit [6:0] m_idx;

  always @(posedge clk) begin
    bit w61, w70, r61, ndp, ndi, qp, qi, nstp, nsti;
    if (rst) begin
      {m_stp, m_sti, m_spk, m_gate, m_tog, m_qp, m_qi, m_rw} = '0;
      m_dp = 1; m_di = 1; m_mask = 1; m_nmi = 1; m_rd = 0; m_idx = 0;
    end else begin
      w61 = io_wr && io_addr == 16'h61;
      w70 = io_wr && io_addr == 16'h70;
      r61 = io_rd && io_addr == 16'h61;
      ndp = w61 ? io_wdata[2] : m_dp;
      ndi = w61 ? io_wdata[3] : m_di;
      qp = perr_evt && !m_dp;
      qi = !iochk_n && !m_di;
      nstp = (m_stp || (qp && !m_qp)) && !ndp;
      nsti = (m_sti || (qi && !m_qi)) && !ndi;
      m_rd = r61 ? {m_stp, m_sti, spk_tmr_out, m_tog, m_di, m_dp, m_spk, m_gate} : 8'h00;
      m_nmi = !((m_stp || m_sti) && !m_mask);
      m_rw = w70;
      if (w70) begin m_mask = io_wdata[7]; m_idx = io_wdata[6:0]; end
      if (w61) begin m_spk = io_wdata[1]; m_gate = io_wdata[0]; end
      m_tog ^= refresh_pulse;
      m_qp = qp; m_qi = qi; m_dp = ndp; m_di = ndi; m_stp = nstp; m_sti = nsti;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) if (!rst && !done) begin
    chk("R6 nmi_n", nmi_n, m_nmi);
    chk("R1 io_rdata", io_rdata, m_rd);
    chk("R7 spk_data/tmr_gate", {spk_data, tmr_gate}, {m_spk, m_gate});
    chk("R8 rtc_idx_wr", rtc_idx_wr, m_rw);
    if (rtc_idx_wr) chk("R8 rtc_idx", rtc_idx, m_idx);
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd61(output logic [7:0] v);
    io_addr = 16'h61; io_rd = 1;
    @(negedge clk); io_rd = 0; v = io_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk("R10 nmi_n", nmi_n, 1);
    chk("R10 outputs", {spk_data, tmr_gate, rtc_idx_wr}, 0);
    rd61(v); chk("R10 readback", v, 8'h0C);
    // R8 unmask, index pass-through
    wr(16'h70, 8'h05);
    chk("R8 idx", {rtc_idx_wr, rtc_idx}, {1'b1, 7'h05});
    // R9 upper bits ignored, R7 low bits stored
    wr(16'h61, 8'hF3);
    rd61(v); chk("R9 readback", v, 8'h03);
    // R2 parity latch and hold
    perr_evt = 1; idle(1); perr_evt = 0; idle(1);
    chk("R6 nmi low", nmi_n, 0);
    rd61(v); chk("R2 status held", v, 8'h83);
    // R4 clear by pulse
    wr(16'h61, 8'h07); wr(16'h61, 8'h03); idle(1);
    chk("R4 cleared nmi", nmi_n, 1);
    // R3 channel check, R6 mask
    iochk_n = 0; idle(2);
    chk("R3 nmi low", nmi_n, 0);
    wr(16'h70, 8'h80); idle(1);
    chk("R6 masked", nmi_n, 1);
    wr(16'h70, 8'h00); idle(1);
    // R11 disable/re-enable while still active
    wr(16'h61, 8'h0B); wr(16'h61, 8'h03); idle(2);
    rd61(v); chk("R11 reset on reenable", v[6], 1);
    iochk_n = 1; wr(16'h61, 8'h0B); wr(16'h61, 8'h03);
    // R4 clear wins over same-cycle edge
    io_addr = 16'h61; io_wdata = 8'h07; io_wr = 1; perr_evt = 1;
    @(negedge clk); io_wr = 0; perr_evt = 0; idle(1);
    rd61(v); chk("R4 clear wins", v[7], 0);
    // R5 refresh toggle coinciding with read
    refresh_pulse = 1; idle(1);
    io_addr = 16'h61; io_rd = 1; @(negedge clk); io_rd = 0; refresh_pulse = 0;
    chk("R5 toggle old on read", io_rdata[4], 1);
    rd61(v); chk("R5 toggle twice", v[4], 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      io_addr = (r < 4) ? 16'h61 : (r < 8) ? 16'h70 : 16'h42;
      io_wdata = 8'($urandom);
      io_wr = ($urandom_range(0, 3) == 0);
      io_rd = ($urandom_range(0, 2) == 0);
      perr_evt = ($urandom_range(0, 5) == 0);
      iochk_n = ($urandom_range(0, 5) != 0);
      spk_tmr_out = 1'($urandom);
      refresh_pulse = ($urandom_range(0, 3) == 0);
      @(negedge clk);
    end
    io_wr = 0; io_rd = 0; idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1; n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule